// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block watches a parameterised number of general-purpose input lines (up to 64; the two intended builds use 36 and 30). Each line is brought into the clock domain through a two-stage synchroniser. An edge detector compares the synchronised level with the level seen one cycle earlier. A per-line polarity bit chooses whether a rising or a falling transition counts. A detected transition latches a pending bit for that line.

Software reaches four per-line registers over a simple word-addressed bus: enable, polarity, pending status and wake-up enable. Writes complete in one cycle and reads are combinational. Each register spans two 32-bit words. The low word holds lines 0 to 31 and the next word up holds lines 32 to 63, at bit position line mod 32. Pending bits are cleared by writing 1. One interrupt output reports any pending line that is enabled. A separate wake-request output reports any pending line marked for wake-up.

Top module: `gpio_edge_irq`

## Requirements
- R1: While reset is asserted, and on the cycle after, every enable, polarity, status and wake-up bit reads 0, and `irq_out` and `wake_req` are 0.
- R2: Word addresses are fixed: enable 0/1, polarity 2/3, status 4/5, wake-up 6/7. Even words hold lines 0-31 and odd words hold lines 32-63 at bit (line mod 32). Enable, polarity and wake-up words read back what was written.
- R3: With polarity 0, a 0-to-1 change on a line sets its status bit on the third rising clock edge after the change, and not before.
- R4: With polarity 1, a 1-to-0 change on a line sets its status bit.
- R5: A transition in the direction the polarity bit does not select leaves the status bit at 0.
- R6: A detected edge sets the status bit even when the line's enable bit is 0.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. Writing to a status word never sets a bit.
- R8: If an edge is detected in the same cycle that a clearing write hits the same status bit, the bit stays set.
- R9: `irq_out` is 1 exactly when some line has both its status bit and its enable bit set.
- R10: `wake_req` is 1 exactly when some line has both its status bit and its wake-up bit set.
- R11: Bits for lines at or above NUM_LINES read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gpio_in | input | NUM_LINES | Asynchronous input lines |
| bus_word_addr | input | 3 | Word address of the register access |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_word_addr`, combinational |
| irq_out | output | 1 | Combined interrupt from enabled pending lines |
| wake_req | output | 1 | Wake request from wake-enabled pending lines |

## Verification
A line change is registered by the first synchroniser stage on the next edge and by the second stage on the edge after that. The edge is flagged while the second stage differs from the stored previous level, so the status bit sets on the third edge. The bench probes the status word after the second edge, where it must still be 0, and again after the third, where it must be set. Register writes take effect on the edge that samples the strobe. Read data and both outputs follow the registers combinationally, so the bench drives and samples on falling edges. The same-cycle race is staged by placing the clearing strobe on exactly the third edge.

// File: rtl/gpei_pkg.sv
package gpei_pkg;
  localparam int MAX_LINES = 64;
  localparam int WORD_W    = 32;

  typedef enum logic [1:0] {
    REG_EN   = 2'd0,
    REG_POL  = 2'd1,
    REG_STS  = 2'd2,
    REG_WAKE = 2'd3
  } reg_kind_e;

  // Bits that correspond to implemented lines
  function automatic logic [MAX_LINES-1:0] line_mask(input int n);
    logic [MAX_LINES-1:0] m;
    for (int i = 0; i < MAX_LINES; i++) m[i] = (i < n);
    return m;
  endfunction

  // Select the 32-bit half holding lines 0-31 (hi=0) or 32-63 (hi=1)
  function automatic logic [WORD_W-1:0] half_of(input logic [MAX_LINES-1:0] v,
                                                input logic hi);
    return hi ? v[MAX_LINES-1:WORD_W] : v[WORD_W-1:0];
  endfunction

  // Replace one half of a 64-bit vector with a word
  function automatic logic [MAX_LINES-1:0] half_put(input logic [MAX_LINES-1:0] old,
                                                   input logic hi,
                                                   input logic [WORD_W-1:0] d);
    logic [MAX_LINES-1:0] r;
    r = old;
    if (hi) r[MAX_LINES-1:WORD_W] = d;
    else    r[WORD_W-1:0]         = d;
    return r;
  endfunction
endpackage

// File: rtl/gpei_edge_detect.sv
module gpei_edge_detect #(
  parameter int LANES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] pin,
  input  logic [LANES-1:0] falling_sel,
  output logic [LANES-1:0] edge_hit
);
  logic [LANES-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic rose, fell;
    assign rose        = sync_q[i] & ~prev_q[i];
    assign fell        = ~sync_q[i] & prev_q[i];
    assign edge_hit[i] = falling_sel[i] ? fell : rose;
  end
endmodule

// File: rtl/gpei_regs.sv
module gpei_regs
  import gpei_pkg::*;
#(
  parameter logic [MAX_LINES-1:0] LMASK = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           word_addr,
  input  logic                 wen,
  input  logic [WORD_W-1:0]    wdata,
  input  logic [MAX_LINES-1:0] edge_hit,
  output logic [WORD_W-1:0]    rdata,
  output logic [MAX_LINES-1:0] enable,
  output logic [MAX_LINES-1:0] polarity,
  output logic [MAX_LINES-1:0] status,
  output logic [MAX_LINES-1:0] wake_en,
  output logic [MAX_LINES-1:0] clr_hit
);
  reg_kind_e kind;
  logic      hi;
  logic [MAX_LINES-1:0] sel;

  assign kind = reg_kind_e'(word_addr[2:1]);
  assign hi   = word_addr[0];

  // Bits a write to the status word asks to clear
  assign clr_hit = (wen && kind == REG_STS) ? (half_put('0, hi, wdata) & LMASK) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable   <= '0;
      polarity <= '0;
      status   <= '0;
      wake_en  <= '0;
    end else begin
      if (wen && kind == REG_EN)   enable   <= half_put(enable,   hi, wdata) & LMASK;
      if (wen && kind == REG_POL)  polarity <= half_put(polarity, hi, wdata) & LMASK;
      if (wen && kind == REG_WAKE) wake_en  <= half_put(wake_en,  hi, wdata) & LMASK;
      // a fresh edge wins over a clear in the same cycle
      status <= (status & ~clr_hit) | (edge_hit & LMASK);
    end
  end

  always_comb begin
    case (kind)
      REG_EN:   sel = enable;
      REG_POL:  sel = polarity;
      REG_STS:  sel = status;
      default:  sel = wake_en;
    endcase
    rdata = half_of(sel, hi);
  end
endmodule

// File: rtl/gpei_aggregate.sv
module gpei_aggregate #(
  parameter int LANES = 64
) (
  input  logic [LANES-1:0] status,
  input  logic [LANES-1:0] enable,
  input  logic [LANES-1:0] wake_en,
  output logic             irq_out,
  output logic             wake_req
);
  assign irq_out  = |(status & enable);
  assign wake_req = |(status & wake_en);
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpei_pkg::*;
#(
  parameter int NUM_LINES = 36
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] gpio_in,
  input  logic [2:0]           bus_word_addr,
  input  logic                 bus_wen,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 irq_out,
  output logic                 wake_req
);
  localparam logic [MAX_LINES-1:0] LMASK = line_mask(NUM_LINES);

  logic [MAX_LINES-1:0] gpio_wide;
  logic [MAX_LINES-1:0] edge_hit, enable, polarity, status, wake_en, clr_hit;

  always_comb begin
    gpio_wide = '0;
    gpio_wide[NUM_LINES-1:0] = gpio_in;
  end

  gpei_edge_detect #(.LANES(MAX_LINES)) u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin         (gpio_wide),
    .falling_sel (polarity),
    .edge_hit    (edge_hit)
  );

  gpei_regs #(.LMASK(LMASK)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_addr (bus_word_addr),
    .wen       (bus_wen),
    .wdata     (bus_wdata),
    .edge_hit  (edge_hit),
    .rdata     (bus_rdata),
    .enable    (enable),
    .polarity  (polarity),
    .status    (status),
    .wake_en   (wake_en),
    .clr_hit   (clr_hit)
  );

  gpei_aggregate #(.LANES(MAX_LINES)) u_agg (
    .status   (status),
    .enable   (enable),
    .wake_en  (wake_en),
    .irq_out  (irq_out),
    .wake_req (wake_req)
  );
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter logic [63:0] LMASK = '1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_out,
  input logic        wake_req,
  input logic [63:0] status,
  input logic [63:0] enable,
  input logic [63:0] wake_en,
  input logic [63:0] edge_hit,
  input logic [63:0] clr_hit
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (status == '0 && enable == '0 && wake_en == '0));

  // R3
  edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != '0) |=> ((status & $past(edge_hit)) == $past(edge_hit)));

  // R8
  edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_hit & clr_hit) != '0) |=>
      ((status & $past(edge_hit & clr_hit)) == $past(edge_hit & clr_hit)));

  // R7
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_hit & ~edge_hit) != '0) |=> ((status & $past(clr_hit & ~edge_hit)) == '0));

  // R7
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(edge_hit)) == '0));

  // R9
  irq_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == ((status & enable) != '0));

  // R10
  wake_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req == ((status & wake_en) != '0));

  // R11
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status | enable | wake_en) & ~LMASK) == '0);
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.LMASK(LMASK)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_out  (irq_out),
  .wake_req (wake_req),
  .status   (status),
  .enable   (enable),
  .wake_en  (wake_en),
  .edge_hit (edge_hit),
  .clr_hit  (clr_hit)
);

// File: tb/tb_gpio_edge_irq.sv
`timescale 1ns/1ps
module tb_gpio_edge_irq;
  localparam int N = 36;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  gpio_in;
  logic [2:0]    bus_word_addr;
  logic          bus_wen;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic          irq_out, wake_req;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  gpio_edge_irq #(.NUM_LINES(N)) dut (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in),
    .bus_word_addr(bus_word_addr), .bus_wen(bus_wen), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out), .wake_req(wake_req)
  );

  // {word address, write data, expected readback} for N = 36
  localparam logic [66:0] VEC [8] = '{
    {3'd0, 32'hA5A5_A5A5, 32'hA5A5_A5A5},  // R2 enable low
    {3'd1, 32'hFFFF_FFFF, 32'h0000_000F},  // R11 enable high
    {3'd2, 32'h1234_5678, 32'h1234_5678},  // R2 polarity low
    {3'd3, 32'h0000_003C, 32'h0000_000C},  // R11 polarity high
    {3'd6, 32'h0F0F_0000, 32'h0F0F_0000},  // R2 wake low
    {3'd7, 32'h0000_0009, 32'h0000_0009},  // R2 wake high
    {3'd4, 32'hFFFF_FFFF, 32'h0000_0000},  // R7 status never set by write
    {3'd5, 32'hFFFF_FFFF, 32'h0000_0000}   // R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_word_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_word_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; gpio_in = '0; bus_word_addr = '0; bus_wen = 1'b0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), r);
      check("R1 reset word", r, 32'h0);
    end
    check("R1 irq after reset", {31'd0, irq_out}, 32'd0);
    check("R1 wake after reset", {31'd0, wake_req}, 32'd0);

    // R2 R11 R7 vector table
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][66:64], VEC[i][63:32]);
      rd(VEC[i][66:64], r);
      check("R2/R11/R7 table", r, VEC[i][31:0]);
    end
    check("R9 no pending no irq", {31'd0, irq_out}, 32'd0);
    check("R10 no pending no wake", {31'd0, wake_req}, 32'd0);
    for (int a = 0; a < 8; a++) if (a != 4 && a != 5) wr(3'(a), 32'h0);

    // R3 timing of a rising edge on line 3, enable off (R6)
    @(negedge clk) gpio_in[3] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk) bus_word_addr = 3'd4; #0.5;
    check("R3 not yet after two edges", bus_rdata, 32'h0);
    @(posedge clk);
    @(negedge clk); #0.5;
    check("R3 set on third edge", bus_rdata, 32'h8);
    check("R6 pending while disabled, irq low", {31'd0, irq_out}, 32'd0);
    wr(3'd0, 32'h8);
    check("R9 irq when enabled", {31'd0, irq_out}, 32'd1);
    wr(3'd4, 32'h0);
    rd(3'd4, r);
    check("R7 write 0 keeps", r, 32'h8);
    wr(3'd4, 32'h8);
    rd(3'd4, r);
    check("R7 write 1 clears", r, 32'h0);
    check("R9 irq drops", {31'd0, irq_out}, 32'd0);
    wr(3'd0, 32'h0);

    // R5 falling on a rising-selected line
    @(negedge clk) gpio_in[3] = 1'b0;
    settle();
    rd(3'd4, r);
    check("R5 falling ignored on rising line", r, 32'h0);

    // R4 / R5 on line 33 (high word bit 1), falling selected
    wr(3'd3, 32'h2);
    @(negedge clk) gpio_in[33] = 1'b1;
    settle();
    rd(3'd5, r);
    check("R5 rising ignored on falling line", r, 32'h0);
    @(negedge clk) gpio_in[33] = 1'b0;
    settle();
    rd(3'd5, r);
    check("R4 falling edge sets high word bit", r, 32'h2);
    check("R10 no wake before wake enable", {31'd0, wake_req}, 32'd0);
    wr(3'd7, 32'h2);
    check("R10 wake request", {31'd0, wake_req}, 32'd1);
    check("R9 irq stays low when disabled", {31'd0, irq_out}, 32'd0);
    wr(3'd5, 32'h2);
    check("R10 wake drops after clear", {31'd0, wake_req}, 32'd0);

    // R8 clear collides with edge on line 5
    @(negedge clk) gpio_in[5] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk) begin bus_word_addr = 3'd4; bus_wdata = 32'h20; bus_wen = 1'b1; end
    @(posedge clk);
    @(negedge clk) bus_wen = 1'b0; #0.5;
    check("R8 edge wins over clear", bus_rdata, 32'h20);
    wr(3'd4, 32'h20);
    rd(3'd4, r);
    check("R7 later clear works", r, 32'h0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule